// File: doc/BRIEF.md
# Stack Processor Arithmetic-Group Executor

This unit carries out one arithmetic-group instruction of a 16-bit processor that keeps its data and return addresses on two stacks. The caller hands over the low twelve opcode bits together with the current top-of-stack word, the word beneath it, the carry flag and the instruction pointer. It raises a one-cycle start strobe. One clock later the unit presents the new top-of-stack and the new carry. Alongside them it gives the number of data-stack entries to pop, an optional return-address push and an optional jump target, all qualified by a one-cycle done pulse.

Inside one instruction, independent opcode flags select a chain of steps that always run in the same order. The steps are ones-complement, increment, a carry edit that can be made conditional on the sign, a two-operand function, and then a rotate through carry or a byte swap. The unit has no stack storage and fetches nothing. The surrounding core pops, pushes and redirects fetch according to the strobes.

Top module: `stk_alu_exec`

## Requirements
- R1: Opcode bit 0 ones-complements TOS and bit 1 then adds one to it, modulo 2^16, in that order; neither step touches carry.
- R2: The carry edit in bits 3..2 leaves carry unchanged for 0, inverts it for 1, clears it for 2 and sets it for 3.
- R3: When bit 4 is set, the carry edit takes effect only if bit 15 of TOS is 1 after the complement and increment steps; when bit 4 is clear it always takes effect.
- R4: Bits 9..8 select the function applied to TOS and operand B: 0 adds with carry-in and takes the new carry from bit 16 of the 17-bit sum, 1 is AND, 2 is OR, 3 is XOR.
- R5: For AND, OR and XOR the carry leaving the function step equals the carry entering it.
- R6: Bit 7 clear makes B the next-on-stack word, which is consumed; bit 7 set makes B the constant 0xFFFF, and no data-stack entry is consumed for it.
- R7: Bits 6..5 equal to 1 rotate the 17-bit ring {carry, TOS} right by one, so the old bit 0 goes to carry and the old carry to bit 15. Equal to 2, they rotate it left, so the old bit 15 goes to carry and the old carry to bit 0. Equal to 0, they leave both unchanged.
- R8: Bits 6..5 equal to 3 exchange the high and low bytes of TOS and leave carry unchanged.
- R9: Bit 10 requests a call-stack push whose value is the instruction pointer supplied with the instruction.
- R10: Bit 11 requests a jump whose target is the final computed value; that value is then dropped. With bit 7 set, the reported TOS is the supplied next-on-stack word and the pop count is 1. With bit 7 clear, the reported TOS is 0 and the pop count is 2, so the core refills TOS from memory. Without a jump, the pop count is 1 when bit 7 is clear and 0 when it is set.
- R11: Results appear with done high exactly one clock after start; done is low in any cycle not preceded by a start, and the pop, push and jump strobes are zero whenever done is low.
- R12: After reset, done and all strobes are low and TOS, carry and the target are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Execute the presented instruction this cycle |
| op_i | input | 12 | Low opcode bits of an arithmetic-group instruction |
| tos_i | input | 16 | Current top-of-stack word |
| nos_i | input | 16 | Current next-on-stack word |
| carry_i | input | 1 | Current carry flag |
| ip_i | input | 16 | Instruction pointer for the return-address push |
| done_o | output | 1 | Result valid, one cycle |
| tos_o | output | 16 | New top-of-stack |
| carry_o | output | 1 | New carry flag |
| pop_cnt_o | output | 2 | Data-stack entries to pop |
| ret_push_o | output | 1 | Push ret_addr_o to the call stack |
| ret_addr_o | output | 16 | Value for the call-stack push |
| jump_o | output | 1 | Load the instruction pointer from jump_tgt_o |
| jump_tgt_o | output | 16 | Jump target |

## Verification
The hardest case to reach is a conditional carry edit whose outcome depends on the sign only after the complement and increment have run. Examples are 0x7FFF, which turns negative when incremented, and 0x0000, which turns negative when complemented. Random operands hit these sign transitions rarely. The stimulus therefore walks all 4096 opcodes several times, and on each pass draws TOS from a small set of such edge words mixed with random values, with random carry and NOS. Directed vectors then pin each step with operands whose expected results are worked out by hand.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_OR  = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    CC_KEEP = 2'd0,
    CC_FLIP = 2'd1,
    CC_CLR  = 2'd2,
    CC_SET  = 2'd3
  } cc_e;

  typedef enum logic [1:0] {
    ROT_NONE  = 2'd0,
    ROT_RIGHT = 2'd1,
    ROT_LEFT  = 2'd2,
    ROT_SWAP  = 2'd3
  } rot_e;

  // field positions fixed by the instruction encoding
  typedef struct packed {
    logic    jump;
    logic    retp;
    alu_fn_e fn;
    logic    bsel;
    rot_e    rot;
    logic    cneg;
    cc_e     cc;
    logic    inc;
    logic    cpl;
  } alu_op_t;

  localparam int unsigned OP_W = $bits(alu_op_t);

endpackage

// File: rtl/stk_pre.sv
module stk_pre
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  input  logic              cpl_i,
  input  logic              inc_i,
  input  logic              cneg_i,
  input  cc_e               cc_i,
  output logic [DATA_W-1:0] a_o,
  output logic              c_o
);
  logic [DATA_W-1:0] a_cpl;
  logic              edit_en;

  always_comb begin
    a_cpl   = cpl_i ? ~a_i : a_i;
    a_o     = inc_i ? a_cpl + DATA_W'(1) : a_cpl;
    edit_en = !cneg_i || a_o[DATA_W-1];
    c_o     = c_i;
    if (edit_en) begin
      unique case (cc_i)
        CC_KEEP: c_o = c_i;
        CC_FLIP: c_o = ~c_i;
        CC_CLR:  c_o = 1'b0;
        CC_SET:  c_o = 1'b1;
      endcase
    end
  end

  // sign-qualified edit must never move carry on a non-negative result
  always_comb begin
    if (!$isunknown({a_i, c_i, cpl_i, inc_i, cneg_i, cc_i}))
      if (cneg_i && !a_o[DATA_W-1])
        p_cneg_hold_r3: assert (c_o == c_i);
  end
endmodule

// File: rtl/stk_logic.sv
module stk_logic
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  input  alu_fn_e           fn_i,
  output logic [DATA_W-1:0] y_o,
  output logic              c_o
);
  localparam int unsigned SUM_W = DATA_W + 1;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(a_i) + SUM_W'(b_i) + SUM_W'(c_i);
    y_o = a_i;
    c_o = c_i;
    unique case (fn_i)
      FN_ADD: begin y_o = sum[DATA_W-1:0]; c_o = sum[DATA_W]; end
      FN_AND: y_o = a_i & b_i;
      FN_OR:  y_o = a_i | b_i;
      FN_XOR: y_o = a_i ^ b_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i, fn_i}))
      if (fn_i != FN_ADD)
        p_logic_carry_r5: assert (c_o == c_i);
  end
endmodule

// File: rtl/stk_rot.sv
module stk_rot
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  input  rot_e              rot_i,
  output logic [DATA_W-1:0] y_o,
  output logic              c_o
);
  localparam int unsigned HALF = DATA_W / 2;
  logic [DATA_W-1:0] swapped;

  generate
    if (DATA_W % 2 == 0) begin : g_even
      assign swapped = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
    end else begin : g_odd
      assign swapped = a_i;
    end
  endgenerate

  always_comb begin
    y_o = a_i;
    c_o = c_i;
    unique case (rot_i)
      ROT_NONE:  ;
      ROT_RIGHT: {y_o, c_o} = {c_i, a_i};
      ROT_LEFT:  {c_o, y_o} = {a_i, c_i};
      ROT_SWAP:  y_o = swapped;
    endcase
  end

  // every mode permutes the ring bits, never creates or loses ones
  always_comb begin
    if (!$isunknown({a_i, c_i, rot_i})) begin
      p_ring_r7: assert ($countones({c_o, y_o}) == $countones({c_i, a_i}));
      if (rot_i == ROT_SWAP)
        p_swap_carry_r8: assert (c_o == c_i);
    end
  end
endmodule

// File: rtl/stk_alu_exec.sv
module stk_alu_exec
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [11:0]       op_i,
  input  logic [DATA_W-1:0] tos_i,
  input  logic [DATA_W-1:0] nos_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] ip_i,
  output logic              done_o,
  output logic [DATA_W-1:0] tos_o,
  output logic              carry_o,
  output logic [1:0]        pop_cnt_o,
  output logic              ret_push_o,
  output logic [DATA_W-1:0] ret_addr_o,
  output logic              jump_o,
  output logic [DATA_W-1:0] jump_tgt_o
);
  alu_op_t           op;
  logic [DATA_W-1:0] pre_a, b_opnd, fn_y, rot_y, tos_d;
  logic              pre_c, fn_c, rot_c;
  logic [1:0]        pop_d;

  assign op     = alu_op_t'(op_i[OP_W-1:0]);
  assign b_opnd = op.bsel ? '1 : nos_i;

  stk_pre #(.DATA_W(DATA_W)) u_pre (
    .a_i(tos_i), .c_i(carry_i), .cpl_i(op.cpl), .inc_i(op.inc),
    .cneg_i(op.cneg), .cc_i(op.cc), .a_o(pre_a), .c_o(pre_c)
  );

  stk_logic #(.DATA_W(DATA_W)) u_fn (
    .a_i(pre_a), .b_i(b_opnd), .c_i(pre_c), .fn_i(op.fn),
    .y_o(fn_y), .c_o(fn_c)
  );

  stk_rot #(.DATA_W(DATA_W)) u_rot (
    .a_i(fn_y), .c_i(fn_c), .rot_i(op.rot), .y_o(rot_y), .c_o(rot_c)
  );

  // jump drops the result; NOS surfaces only if the function left it on the stack
  always_comb begin
    pop_d = {1'b0, ~op.bsel} + {1'b0, op.jump};
    if (op.jump) tos_d = op.bsel ? nos_i : '0;
    else         tos_d = rot_y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      tos_o      <= '0;
      carry_o    <= 1'b0;
      pop_cnt_o  <= '0;
      ret_push_o <= 1'b0;
      ret_addr_o <= '0;
      jump_o     <= 1'b0;
      jump_tgt_o <= '0;
    end else begin
      done_o     <= start_i;
      pop_cnt_o  <= start_i ? pop_d : 2'd0;
      ret_push_o <= start_i & op.retp;
      jump_o     <= start_i & op.jump;
      if (start_i) begin
        tos_o      <= tos_d;
        carry_o    <= rot_c;
        ret_addr_o <= ip_i;
        jump_tgt_o <= rot_y;
      end
    end
  end

  p_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_no_spurious_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!jump_o && !ret_push_o && pop_cnt_o == 2'd0));
  p_ret_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[10]) |=> (ret_push_o && ret_addr_o == $past(ip_i)));
  p_pop_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pop_cnt_o <= 2'd2));
endmodule

// File: tb/sim_stk_alu_exec.sv
module sim_stk_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] op = '0;
  logic [15:0] tos = '0, nos = '0, ip = '0;
  logic        cin = 1'b0;
  logic        done, cout, ret_push, jump;
  logic [15:0] tos_out, ret_addr, tgt;
  logic [1:0]  pop_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  stk_alu_exec u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .tos_i(tos), .nos_i(nos), .carry_i(cin), .ip_i(ip),
    .done_o(done), .tos_o(tos_out), .carry_o(cout), .pop_cnt_o(pop_cnt),
    .ret_push_o(ret_push), .ret_addr_o(ret_addr), .jump_o(jump),
    .jump_tgt_o(tgt)
  );

  // expected results
  logic [15:0] e_tos, e_tgt;
  logic        e_c;
  int          e_pop;

  task automatic model(input logic [11:0] o, input logic [15:0] t0,
                       input logic [15:0] n0, input logic c0);
    int t, b, s, c;
    t = t0; c = c0;
    if (o[0]) t = (~t) & 16'hFFFF;
    if (o[1]) t = (t + 1) & 16'hFFFF;
    if (!o[4] || ((t >> 15) & 1) == 1) begin
      case (o[3:2])
        2'd1: c = 1 - c;
        2'd2: c = 0;
        2'd3: c = 1;
        default: ;
      endcase
    end
    b = o[7] ? 16'hFFFF : int'(n0);
    case (o[9:8])
      2'd0: begin s = t + b + c; t = s & 16'hFFFF; c = (s >> 16) & 1; end
      2'd1: t = t & b;
      2'd2: t = t | b;
      default: t = t ^ b;
    endcase
    case (o[6:5])
      2'd1: begin s = t & 1; t = (t >> 1) | (c << 15); c = s; end
      2'd2: begin s = (t >> 15) & 1; t = ((t << 1) & 16'hFFFF) | c; c = s; end
      2'd3: t = ((t & 8'hFF) << 8) | ((t >> 8) & 8'hFF);
      default: ;
    endcase
    e_tgt = 16'(t);
    e_c   = c[0];
    e_pop = (o[7] ? 0 : 1) + (o[11] ? 1 : 0);
    if (o[11]) e_tos = o[7] ? n0 : 16'h0000;
    else       e_tos = 16'(t);
  endtask

  task automatic fail(input string req, input string what,
                      input int act, input int exp);
    n_bad++;
    $display("FAIL %s %s op=%h: actual %h expected %h", req, what, op, act, exp);
  endtask

  // one instruction; compares every output the cycle after start
  task automatic run(input logic [11:0] o, input logic [15:0] t0,
                     input logic [15:0] n0, input logic c0,
                     input logic [15:0] i0, input string req);
    logic bad;
    @(negedge clk);
    op = o; tos = t0; nos = n0; cin = c0; ip = i0; start = 1'b1;
    model(o, t0, n0, c0);
    @(negedge clk);
    start = 1'b0;
    n_chk++;
    bad = 1'b0;
    if (done !== 1'b1) begin fail("R11", "done", done, 1); bad = 1'b1; end
    if (tos_out !== e_tos) begin fail(req, "tos", tos_out, e_tos); bad = 1'b1; end
    if (cout !== e_c) begin fail("R2", "carry", cout, e_c); bad = 1'b1; end
    if (int'(pop_cnt) != e_pop) begin fail("R6", "pop", pop_cnt, e_pop); bad = 1'b1; end
    if (ret_push !== o[10]) begin fail("R9", "ret_push", ret_push, o[10]); bad = 1'b1; end
    if (o[10] && ret_addr !== i0) begin fail("R9", "ret_addr", ret_addr, i0); bad = 1'b1; end
    if (jump !== o[11]) begin fail("R10", "jump", jump, o[11]); bad = 1'b1; end
    if (o[11] && tgt !== e_tgt) begin fail("R10", "target", tgt, e_tgt); bad = 1'b1; end
    if (bad) n_chk += 0;
  endtask

  // hand-worked expectations
  task automatic direct(input string req, input logic [11:0] o,
                        input logic [15:0] t0, input logic [15:0] n0,
                        input logic c0, input logic [15:0] x_tos,
                        input logic x_c);
    @(negedge clk);
    op = o; tos = t0; nos = n0; cin = c0; ip = 16'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_chk++;
    if (tos_out !== x_tos || cout !== x_c) begin
      n_bad++;
      $display("FAIL %s op=%h: actual tos=%h c=%0b expected tos=%h c=%0b",
               req, o, tos_out, cout, x_tos, x_c);
    end
  endtask

  task automatic expect_bit(input string req, input string what,
                            input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  logic [15:0] edges [6] = '{16'h0000, 16'h7FFF, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFE};

  initial begin
    #1;
    #20;
    // R12: reset state
    n_chk++;
    if (done !== 1'b0 || pop_cnt !== 2'd0 || ret_push !== 1'b0 || jump !== 1'b0 ||
        tos_out !== 16'h0 || cout !== 1'b0 || tgt !== 16'h0) begin
      n_bad++;
      $display("FAIL R12 reset: actual done=%0b tos=%h expected 0", done, tos_out);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: complement then increment negates; AND with 0xFFFF is neutral
    direct("R1", 12'h183, 16'h0005, 16'h0, 1'b0, 16'hFFFB, 1'b0);
    // R2: carry edit encodings
    direct("R2", 12'h184, 16'h1234, 16'h0, 1'b1, 16'h1234, 1'b0);
    direct("R2", 12'h188, 16'h1234, 16'h0, 1'b1, 16'h1234, 1'b0);
    direct("R2", 12'h18C, 16'h1234, 16'h0, 1'b0, 16'h1234, 1'b1);
    // R3: sign taken after increment
    direct("R3", 12'h19E, 16'h7FFF, 16'h0, 1'b0, 16'h8000, 1'b1);
    direct("R3", 12'h19C, 16'h7FFF, 16'h0, 1'b0, 16'h7FFF, 1'b0);
    // R4: add carry out from bit 16
    direct("R4", 12'h000, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1);
    direct("R4", 12'h200, 16'h0F0F, 16'h00F0, 1'b0, 16'h0FFF, 1'b0);
    // R5: XOR keeps carry
    direct("R5", 12'h300, 16'hAAAA, 16'h5555, 1'b1, 16'hFFFF, 1'b1);
    // R7: rotates through carry
    direct("R7", 12'h1A0, 16'h0001, 16'h0, 1'b0, 16'h0000, 1'b1);
    direct("R7", 12'h1C0, 16'h8000, 16'h0, 1'b1, 16'h0001, 1'b1);
    // R8: byte swap, carry kept
    direct("R8", 12'h1E0, 16'h12AB, 16'h0, 1'b1, 16'hAB12, 1'b1);
    // R6: constant B consumes nothing
    run(12'h180, 16'h1111, 16'h2222, 1'b0, 16'h0, "R6");
    run(12'h100, 16'h1111, 16'h2222, 1'b0, 16'h0, "R6");
    // R9, R10
    run(12'h580, 16'h1111, 16'h2222, 1'b0, 16'h1234, "R9");
    run(12'h980, 16'h0040, 16'h7777, 1'b0, 16'h0, "R10");
    run(12'h900, 16'h0040, 16'h7777, 1'b0, 16'h0, "R10");
    // R11: pulse lasts one cycle
    @(negedge clk);
    expect_bit("R11", "done after idle", done, 1'b0);
    expect_bit("R11", "jump after idle", jump, 1'b0);

    // sweep every opcode with edge and random operands
    for (int pass = 0; pass < 3; pass++) begin
      for (int o = 0; o < 4096; o++) begin
        logic [15:0] t;
        t = ($urandom % 2 == 0) ? edges[$urandom % 6] : 16'($urandom);
        run(12'(o), t, 16'($urandom), 1'($urandom), 16'($urandom), "R4");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule